// File: doc/BRIEF.md
# Translation Buffer with Entry Pinning

This block is a small fully associative translation cache that maps virtual page numbers to physical page numbers. An issuer sends one command at a time over a valid/ready interface: a lookup, a flush of the whole buffer, a flush of the single entry that matches a virtual page, or a translate-and-pin command. Lookups that hit return the physical address in the same cycle. Lookups that miss, and all pin commands, fetch the translation through a simple request/acknowledge port to an external page walker. The walker supplies a physical page number or a fault.

Pinned entries fill the buffer from slot 0 upward, and a pin counter records how many slots are reserved. Ordinary refills replace entries round-robin over the remaining slots only, so a pinned translation is never evicted by traffic. A walker fault is recorded in a fault status register and signalled as a data-side abort. A fault during a pin command is recorded with its own lock-abort code. A pin request for a page that is already cached, or one made when every slot is pinned, is refused and flagged.

Commands complete strictly in order. A one-cycle done pulse marks the point at which the command's effect is visible to the next command.

Top module: `xlat_pin_buffer`

## Requirements
- R1: A lookup accepted while the virtual page is cached raises lk_hit in the same cycle, with lk_paddr equal to the cached physical page followed by the low OFF_W bits of cmd_vaddr. lk_hit and lk_miss are never high together.
- R2: A lookup of an uncached page raises lk_miss in the accept cycle. From the next cycle walk_req is high with walk_vpn equal to the page. A good walk result is installed, so the same page then hits with the returned physical page.
- R3: A pin command (cmd_op 2'b11) for an uncached page walks and installs the result in slot lock_count, and lock_count rises by one. lock_count only ever rises by one or returns to zero.
- R4: Refills replace slots round-robin from the first unpinned slot. After the last slot the pointer wraps back to lock_count, so a refill never overwrites a pinned slot.
- R5: Flush-all (cmd_op 2'b01) invalidates every entry, and lock_count reads 0 in the cycle after acceptance.
- R6: Flush-one (cmd_op 2'b10) invalidates only the entry that matches the page, and other entries still hit. If that entry was pinned, lock_count does not change.
- R7: A pin command for a page that is already cached raises err_dup with cmd_done. It starts no walk and leaves the contents and lock_count unchanged.
- R8: A pin command when lock_count equals ENTRIES raises err_full with cmd_done and starts no walk.
- R9: A walker fault during a pin command sets fault_status to 2'd2 (lock abort) and pulses abort_data with cmd_done. Nothing is installed and lock_count is unchanged.
- R10: A walker fault during a lookup refill sets fault_status to 2'd1 (walk fault) and pulses abort_data with cmd_done. The page stays uncached.
- R11: cmd_done is a one-cycle pulse in the cycle after the command's state update: the accept edge, or the edge where walk_ack is taken. cmd_ready is low while a walk is outstanding.
- R12: After reset cmd_ready is 1, lock_count is 0, fault_status is 0 and cmd_done and walk_req are 0. Lookup codes are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 lookup, 01 flush all, 10 flush one, 11 translate-and-pin |
| cmd_vaddr | input | VPN_W+OFF_W | Virtual address of the command |
| cmd_ready | output | 1 | Buffer can accept a command |
| cmd_done | output | 1 | Command complete, effect visible |
| lk_hit | output | 1 | Lookup hit (same cycle as accept) |
| lk_miss | output | 1 | Lookup miss (same cycle as accept) |
| lk_paddr | output | PPN_W+OFF_W | Translated address on a hit |
| walk_req | output | 1 | Translation fetch outstanding |
| walk_vpn | output | VPN_W | Page to translate |
| walk_ack | input | 1 | Walker result valid |
| walk_ppn | input | PPN_W | Physical page from walker |
| walk_fault | input | 1 | Walker reports a fault |
| err_dup | output | 1 | Pin refused: page already cached |
| err_full | output | 1 | Pin refused: all slots pinned |
| abort_data | output | 1 | Data-side abort pulse |
| fault_status | output | 2 | Last fault code: 0 none, 1 walk fault, 2 lock abort |
| lock_count | output | $clog2(ENTRIES)+1 | Number of pinned slots |

## Verification
The bench fills every unpinned slot and forces one extra refill. A replacement pointer that wrapped to slot 0 instead of the pin boundary would then evict a pinned page, and a pinned lookup would miss. It pins a page that is already cached and pins into a fully pinned buffer. A design that ignored either refusal would start a walk or move lock_count. Walker faults are injected on both a pin and a lookup. This catches a design that mixes up the two status codes, or that installs a faulted page which later hits.

// File: rtl/xpb_pkg.sv
// Shared definitions for the pinned translation buffer.
// Assumes: 2-bit command code and 2-bit fault status.
package xpb_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP  = 2'b00,
        OP_INV_ALL = 2'b01,
        OP_INV_ONE = 2'b10,
        OP_PIN     = 2'b11
    } xpb_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xpb_state_e;

    localparam logic [1:0] FS_NONE = 2'd0;
    localparam logic [1:0] FS_WALK = 2'd1;
    localparam logic [1:0] FS_LOCK = 2'd2;
endpackage

// File: rtl/xpb_entries.sv
// Entry storage and associative match for the translation buffer.
// Assumes: at most one valid entry matches a page (duplicates are refused
// upstream), so the physical page is an OR over the masked matches.
// Write priority: flush-all, then slot write, then flush-one.
module xpb_entries #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             clr_all,
    input  logic             clr_match,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // Compare this slot against the looked-up page.
        assign match[i] = valid_q[i] && (vpn_q[i] == look_vpn);

        // Update this slot's valid flag and translation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                ppn_q[i]   <= '0;
            end else if (clr_all) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                vpn_q[i]   <= wr_vpn;
                ppn_q[i]   <= wr_ppn;
            end else if (clr_match && match[i]) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    assign hit = |match;

    // Merge the physical page of the single matching slot.
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ppn = hit_ppn | ppn_q[i];
        end
    end
endmodule

// File: rtl/xpb_ptrs.sv
// Pin counter and round-robin replacement pointer.
// Slots [0, lock_cnt) are pinned. The replacement pointer stays in
// [lock_cnt, ENTRIES-1] and wraps from the last slot back to lock_cnt.
// Assumes pin_take and repl_adv are never high in the same cycle.
module xpb_ptrs #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pin_take,
    input  logic             repl_adv,
    output logic [CNT_W-1:0] lock_cnt,
    output logic [IDX_W-1:0] repl_ptr,
    output logic             pool_empty
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    logic [CNT_W-1:0] lock_nxt;

    assign lock_nxt   = lock_cnt + 1'b1;
    assign pool_empty = (lock_cnt == FULL_CNT);

    // Advance the pin count and keep the replacement pointer off pinned slots.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lock_cnt <= '0;
            repl_ptr <= '0;
        end else if (pin_take) begin
            lock_cnt <= lock_nxt;
            if (({1'b0, repl_ptr} < lock_nxt) && (lock_nxt < FULL_CNT))
                repl_ptr <= lock_nxt[IDX_W-1:0];
        end else if (repl_adv) begin
            if (repl_ptr == LAST_IDX)
                repl_ptr <= lock_cnt[IDX_W-1:0];
            else
                repl_ptr <= repl_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xpb_ctrl.sv
// Command sequencer: accepts one command at a time, runs the walk
// handshake for lookup misses and pin commands, and registers the
// completion, refusal and fault reporting.
// Assumes the walker holds walk_ack for one cycle while walk_req is high.
module xpb_ctrl
    import xpb_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [VPN_W-1:0] cmd_vpn,
    input  logic             cam_hit,
    input  logic             pool_empty,
    input  logic             walk_ack,
    input  logic             walk_fault,
    output logic             cmd_ready,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic             pend_pin,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             clr_all,
    output logic             clr_match,
    output logic             pin_take,
    output logic             repl_adv,
    output logic             cmd_done,
    output logic             err_dup,
    output logic             err_full,
    output logic             abort_data,
    output logic [1:0]       fault_status
);
    xpb_state_e st_q;
    logic       accept;
    logic       is_pin;
    logic       start_pin;
    logic       walk_done;
    logic       fill_ok;

    assign cmd_ready = (st_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign is_pin    = (cmd_op == OP_PIN);
    assign walk_req  = (st_q == ST_WALK);

    // Decode the accepted command into strobes for storage and pointers.
    always_comb begin
        lk_hit    = accept && (cmd_op == OP_LOOKUP) && cam_hit;
        lk_miss   = accept && (cmd_op == OP_LOOKUP) && !cam_hit;
        clr_all   = accept && (cmd_op == OP_INV_ALL);
        clr_match = accept && (cmd_op == OP_INV_ONE);
        start_pin = accept && is_pin && !pool_empty && !cam_hit;
        walk_done = walk_req && walk_ack;
        fill_ok   = walk_done && !walk_fault;
        pin_take  = fill_ok && pend_pin;
        repl_adv  = fill_ok && !pend_pin && !pool_empty;
    end

    // Hold the walk state and the page being translated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            pend_pin <= 1'b0;
            walk_vpn <= '0;
        end else if (lk_miss || start_pin) begin
            st_q     <= ST_WALK;
            pend_pin <= start_pin;
            walk_vpn <= cmd_vpn;
        end else if (walk_done) begin
            st_q <= ST_IDLE;
        end
    end

    // Register completion, refusal and abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done   <= 1'b0;
            err_dup    <= 1'b0;
            err_full   <= 1'b0;
            abort_data <= 1'b0;
        end else begin
            cmd_done   <= (accept && !lk_miss && !start_pin) || walk_done;
            err_full   <= accept && is_pin && pool_empty;
            err_dup    <= accept && is_pin && !pool_empty && cam_hit;
            abort_data <= walk_done && walk_fault;
        end
    end

    // Record the kind of the most recent walker fault.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_status <= FS_NONE;
        else if (walk_done && walk_fault)
            fault_status <= pend_pin ? FS_LOCK : FS_WALK;
    end
endmodule

// File: rtl/xlat_pin_buffer.sv
// Top of the pinned translation buffer: joins entry storage, pin and
// replacement pointers, and the command sequencer. A pin installs at
// slot lock_count; a refill installs at the replacement pointer.
// Assumes the issuer waits for cmd_ready before presenting a command.
module xlat_pin_buffer #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [VPN_W+OFF_W-1:0]      cmd_vaddr,
    output logic                        cmd_ready,
    output logic                        cmd_done,
    output logic                        lk_hit,
    output logic                        lk_miss,
    output logic [PPN_W+OFF_W-1:0]      lk_paddr,
    output logic                        walk_req,
    output logic [VPN_W-1:0]            walk_vpn,
    input  logic                        walk_ack,
    input  logic [PPN_W-1:0]            walk_ppn,
    input  logic                        walk_fault,
    output logic                        err_dup,
    output logic                        err_full,
    output logic                        abort_data,
    output logic [1:0]                  fault_status,
    output logic [$clog2(ENTRIES):0]    lock_count
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = IDX_W + 1;

    logic [VPN_W-1:0] cmd_vpn;
    logic             cam_hit;
    logic [PPN_W-1:0] cam_ppn;
    logic             clr_all;
    logic             clr_match;
    logic             pin_take;
    logic             repl_adv;
    logic             pend_pin;
    logic             pool_empty;
    logic [IDX_W-1:0] repl_ptr;
    logic [CNT_W-1:0] lock_cnt;
    logic [IDX_W-1:0] wr_idx;

    assign cmd_vpn    = cmd_vaddr[VPN_W+OFF_W-1:OFF_W];
    assign wr_idx     = pend_pin ? lock_cnt[IDX_W-1:0] : repl_ptr;
    assign lock_count = lock_cnt;
    assign lk_paddr   = lk_hit ? {cam_ppn, cmd_vaddr[OFF_W-1:0]} : '0;

    xpb_entries #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (cmd_vpn),
        .hit       (cam_hit),
        .hit_ppn   (cam_ppn),
        .clr_all   (clr_all),
        .clr_match (clr_match),
        .wr_en     (pin_take || repl_adv),
        .wr_idx    (wr_idx),
        .wr_vpn    (walk_vpn),
        .wr_ppn    (walk_ppn)
    );

    xpb_ptrs #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_all),
        .pin_take   (pin_take),
        .repl_adv   (repl_adv),
        .lock_cnt   (lock_cnt),
        .repl_ptr   (repl_ptr),
        .pool_empty (pool_empty)
    );

    xpb_ctrl #(
        .VPN_W (VPN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_vpn      (cmd_vpn),
        .cam_hit      (cam_hit),
        .pool_empty   (pool_empty),
        .walk_ack     (walk_ack),
        .walk_fault   (walk_fault),
        .cmd_ready    (cmd_ready),
        .walk_req     (walk_req),
        .walk_vpn     (walk_vpn),
        .pend_pin     (pend_pin),
        .lk_hit       (lk_hit),
        .lk_miss      (lk_miss),
        .clr_all      (clr_all),
        .clr_match    (clr_match),
        .pin_take     (pin_take),
        .repl_adv     (repl_adv),
        .cmd_done     (cmd_done),
        .err_dup      (err_dup),
        .err_full     (err_full),
        .abort_data   (abort_data),
        .fault_status (fault_status)
    );
endmodule

// File: rtl/xpb_checker.sv
// Temporal checks for xlat_pin_buffer, attached by bind below.
// Assumes synchronous active-low reset; all properties are off in reset.
module xpb_checker #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int CNT_W   = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             cmd_ready,
    input logic             cmd_done,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             walk_req,
    input logic             walk_ack,
    input logic             err_dup,
    input logic             err_full,
    input logic             abort_data,
    input logic [1:0]       fault_status,
    input logic [CNT_W-1:0] lock_count,
    input logic [IDX_W-1:0] repl_ptr
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    assert_hit_miss_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    assert_lock_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_count) |-> (lock_count == $past(lock_count) + 1'b1) || (lock_count == '0));

    assert_lock_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_count <= FULL_CNT);

    assert_repl_outside_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_count < FULL_CNT) |-> ({1'b0, repl_ptr} >= lock_count));

    assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b01) |=> (lock_count == '0));

    assert_dup_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup |-> (cmd_done && !abort_data && !walk_req));

    assert_full_refusal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |-> (cmd_done && lock_count == FULL_CNT));

    assert_abort_coded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_data |-> (cmd_done && fault_status != 2'd0));

    assert_busy_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !cmd_ready);

    assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ($past(cmd_valid && cmd_ready) || $past(walk_req && walk_ack)));
endmodule

bind xlat_pin_buffer xpb_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ready    (cmd_ready),
    .cmd_done     (cmd_done),
    .lk_hit       (lk_hit),
    .lk_miss      (lk_miss),
    .walk_req     (walk_req),
    .walk_ack     (walk_ack),
    .err_dup      (err_dup),
    .err_full     (err_full),
    .abort_data   (abort_data),
    .fault_status (fault_status),
    .lock_count   (lock_count),
    .repl_ptr     (repl_ptr)
);

// File: tb/sim_xlat_pin_buffer.sv
`timescale 1ns/1ps
module sim_xlat_pin_buffer;
    localparam int ENTRIES = 32;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;
    localparam int OFF_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_vaddr = '0;
    logic        cmd_ready, cmd_done, lk_hit, lk_miss;
    logic [31:0] lk_paddr;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic        walk_fault = 1'b0;
    logic        err_dup, err_full, abort_data;
    logic [1:0]  fault_status;
    logic [5:0]  lock_count;

    int checks = 0;
    int failures = 0;
    int walk_cycles = 0;
    bit finished = 0;

    // Captured results of the last command.
    logic r_hit, r_miss, r_dup, r_full, r_abort;
    logic [31:0] r_paddr;

    xlat_pin_buffer #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vaddr(cmd_vaddr), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
        .walk_ppn(walk_ppn), .walk_fault(walk_fault), .err_dup(err_dup),
        .err_full(err_full), .abort_data(abort_data),
        .fault_status(fault_status), .lock_count(lock_count)
    );

    always #2 clk = ~clk;

    function automatic logic [19:0] ppn_of(input logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Page walker model: answers two cycles into a request; pages 0xFxxxx fault.
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (walk_req) walk_cycles++;
            if (walk_ack) begin
                walk_ack = 1'b0;
                wait_n = 0;
            end else if (walk_req) begin
                wait_n++;
                if (wait_n == 2) begin
                    walk_ack   = 1'b1;
                    walk_ppn   = ppn_of(walk_vpn);
                    walk_fault = (walk_vpn[19:16] == 4'hF);
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    // Issue one command and wait for its done pulse.
    task automatic do_cmd(input logic [1:0] op, input logic [31:0] va);
        int guard = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_vaddr = va;
        #1;
        r_hit = lk_hit; r_miss = lk_miss; r_paddr = lk_paddr;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (walk_req) check(cmd_ready == 1'b0, "R11 ready low during walk", cmd_ready, 0);
        while (!cmd_done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(cmd_done == 1'b1, "R11 done pulse seen", cmd_done, 1);
        r_dup = err_dup; r_full = err_full; r_abort = abort_data;
    endtask

    task automatic expect_done_low();
        @(negedge clk);
        check(cmd_done == 1'b0, "R11 done one cycle", cmd_done, 0);
    endtask

    task automatic test_reset();
        check(cmd_ready == 1'b1, "R12 ready", cmd_ready, 1);
        check(lock_count == 0, "R12 lock_count", lock_count, 0);
        check(fault_status == 2'd0, "R12 fault_status", fault_status, 0);
        check(cmd_done == 1'b0 && walk_req == 1'b0, "R12 idle outputs", {cmd_done, walk_req}, 0);
    endtask

    task automatic test_refill();
        do_cmd(2'b00, 32'h0001_2345);
        check(r_miss == 1'b1 && r_hit == 1'b0, "R2 first lookup misses", {r_hit, r_miss}, 1);
        expect_done_low();
        do_cmd(2'b00, 32'h0001_2ABC);
        check(r_hit == 1'b1, "R1 refilled page hits", r_hit, 1);
        check(r_paddr == {ppn_of(20'h00012), 12'hABC}, "R1 translated address",
              r_paddr, {ppn_of(20'h00012), 12'hABC});
        expect_done_low();
    endtask

    task automatic test_pin_and_dup();
        int w0;
        do_cmd(2'b01, 32'h0);
        do_cmd(2'b11, 32'h1000_0000);
        check(lock_count == 1, "R3 lock_count after pin", lock_count, 1);
        do_cmd(2'b00, 32'h1000_0123);
        check(r_hit == 1'b1 && r_paddr == {ppn_of(20'h10000), 12'h123}, "R3 pinned page hits",
              r_paddr, {ppn_of(20'h10000), 12'h123});
        w0 = walk_cycles;
        do_cmd(2'b11, 32'h1000_0000);
        check(r_dup == 1'b1, "R7 err_dup", r_dup, 1);
        check(walk_cycles == w0, "R7 no walk", walk_cycles, w0);
        check(lock_count == 1, "R7 lock_count unchanged", lock_count, 1);
    endtask

    task automatic test_wrap();
        do_cmd(2'b01, 32'h0);
        check(lock_count == 0, "R5 lock_count cleared", lock_count, 0);
        do_cmd(2'b11, 32'h1000_0000);
        do_cmd(2'b11, 32'h1000_1000);
        check(lock_count == 2, "R3 two pins", lock_count, 2);
        for (int k = 0; k < 31; k++) do_cmd(2'b00, 32'h2000_0000 + (k << 12));
        do_cmd(2'b00, 32'h1000_0000);
        check(r_hit == 1'b1, "R4 pin slot 0 kept", r_hit, 1);
        do_cmd(2'b00, 32'h1000_1000);
        check(r_hit == 1'b1, "R4 pin slot 1 kept", r_hit, 1);
        do_cmd(2'b00, 32'h2000_1000);
        check(r_hit == 1'b1, "R4 second refill kept", r_hit, 1);
        do_cmd(2'b00, 32'h2001_E000);
        check(r_hit == 1'b1, "R4 wrapping refill present", r_hit, 1);
        do_cmd(2'b00, 32'h2000_0000);
        check(r_miss == 1'b1, "R4 oldest refill evicted", r_miss, 1);
    endtask

    task automatic test_flush_one();
        do_cmd(2'b10, 32'h1000_0000);
        check(lock_count == 2, "R6 lock_count kept", lock_count, 2);
        do_cmd(2'b00, 32'h1000_1000);
        check(r_hit == 1'b1, "R6 other pin still hits", r_hit, 1);
        do_cmd(2'b00, 32'h1000_0000);
        check(r_miss == 1'b1, "R6 flushed page misses", r_miss, 1);
    endtask

    task automatic test_flush_all();
        do_cmd(2'b01, 32'h0);
        check(lock_count == 0, "R5 lock_count zero", lock_count, 0);
        do_cmd(2'b00, 32'h1000_1000);
        check(r_miss == 1'b1, "R5 pinned page gone", r_miss, 1);
    endtask

    task automatic test_full();
        int w0;
        do_cmd(2'b01, 32'h0);
        for (int k = 0; k < ENTRIES; k++) do_cmd(2'b11, 32'h3000_0000 + (k << 12));
        check(lock_count == ENTRIES, "R8 all pinned", lock_count, ENTRIES);
        w0 = walk_cycles;
        do_cmd(2'b11, 32'h3004_0000);
        check(r_full == 1'b1, "R8 err_full", r_full, 1);
        check(walk_cycles == w0, "R8 no walk", walk_cycles, w0);
        check(lock_count == ENTRIES, "R8 count unchanged", lock_count, ENTRIES);
    endtask

    task automatic test_faults();
        do_cmd(2'b01, 32'h0);
        do_cmd(2'b11, 32'hF000_1000);
        check(r_abort == 1'b1, "R9 abort on pin fault", r_abort, 1);
        check(fault_status == 2'd2, "R9 lock-abort code", fault_status, 2);
        check(lock_count == 0, "R9 nothing pinned", lock_count, 0);
        do_cmd(2'b00, 32'hF000_1000);
        check(r_miss == 1'b1, "R9 faulted pin not cached", r_miss, 1);
        check(r_abort == 1'b1 && fault_status == 2'd1, "R10 walk fault code", fault_status, 1);
        do_cmd(2'b00, 32'hF000_1000);
        check(r_miss == 1'b1, "R10 faulted refill not cached", r_miss, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_refill();
        test_pin_and_dup();
        test_wrap();
        test_flush_one();
        test_flush_all();
        test_full();
        test_faults();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule